// File: doc/BRIEF.md
# Cascaded Wide Binary Counter and Programmable Divider

This block joins S identical 8-bit presettable up-counter stages on one clock into a single binary counter that is 8×S bits wide. The external enable, which is active low, drives only the least significant stage. Each higher stage is enabled by the OR of the active-low terminal-count flags of every stage below it. A stage therefore advances on the edge where all lower stages read all ones, and on that same edge the lower stages wrap to zero.

A parallel load, also active low, copies a preset word into every stage at the next clock edge, whatever the enable is doing. When divider mode is selected, the chain reloads the preset on the edge after it reaches all ones. The active-low terminal-count output then drops for one clock in every 2^W − preset cycles, and that pulse serves as the divided clock. An asynchronous reset clears every stage at the same moment.

Top module: `wide_count_chain`

## Requirements
- R1: `arst` high clears `countVal` to zero and drives `termN` high immediately, without waiting for a clock edge.
- R2: With `loadN` low, the next rising edge sets `countVal` to `presetVal`, whatever the values of `cntEnN` and `divMode`.
- R3: With `loadN` high and `cntEnN` low, each rising edge adds one to `countVal`, modulo 2^W. The exception is the reload of R7.
- R4: With `cntEnN` high, the least significant stage holds its value. A higher stage still advances by one on an edge where every stage below it reads all ones.
- R5: A carry across a stage boundary happens on a single edge. For example, 0x00FF steps to 0x0100 with no intermediate value.
- R6: `termN` is low in exactly the cycles in which `countVal` is all ones. It follows the count in the same cycle.
- R7: In divider mode (`divMode` = 1), an edge that finds `countVal` all ones loads `presetVal`, even when `cntEnN` is high.
- R8: In divider mode with `cntEnN` low, falling edges of `termN` are 2^W − `presetVal` cycles apart, and each low pulse lasts one cycle when `presetVal` is below 2^W − 1.
- R9: With `divMode` = 0, the chain wraps from all ones to zero and does not reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all stages, active on the rising edge |
| arst | input | 1 | Asynchronous reset, active high |
| cntEnN | input | 1 | Count enable for the least significant stage, active low |
| loadN | input | 1 | Parallel load of the preset into all stages, active low |
| divMode | input | 1 | 1 reloads the preset on chain terminal count, 0 lets the chain wrap |
| presetVal | input | 8×STAGES | Preset word; bits [8k+7:8k] belong to stage k |
| countVal | output | 8×STAGES | Current count of the whole chain |
| termN | output | 1 | Chain terminal count, low while every stage is all ones |

## Verification
Every load, increment, carry and divider reload shows on `countVal` one edge after the inputs that cause it, because each stage has a single register and no pipeline. `termN` is decoded from those registers, so it is valid in the same cycle as the count it reflects. The reset clears the outputs at once, with no edge involved. The bench drives inputs one time unit after a rising edge and checks the outputs one time unit after the next rising edge, against a reference word advanced once per edge. The reset is checked between edges. Divider periods are measured as the number of edges between successive low samples of `termN`.

// File: rtl/wcc_pkg.sv
`timescale 1ns/1ps
package wcc_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // copy preset into every stage on the next edge
    logic lsbEn;  // advance the least significant stage
  } wccStrobes_t;
endpackage

// File: rtl/wcc_stage.sv
`timescale 1ns/1ps
module wcc_stage #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          arst,
  input  logic          load,
  input  logic          enN,
  input  logic [SW-1:0] presetSlice,
  output logic [SW-1:0] q,
  output logic          tcN
);
  always_ff @(posedge clk or posedge arst) begin
    if (arst)      q <= '0;
    else if (load) q <= presetSlice;
    else if (!enN) q <= q + 1'b1;
  end

  assign tcN = ~(&q);
endmodule

// File: rtl/wcc_ctrl.sv
`timescale 1ns/1ps
module wcc_ctrl
  import wcc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic              cntEnN,
  input  logic              loadN,
  input  logic              divMode,
  input  logic [STAGES-1:0] stageTcN,
  output wccStrobes_t       strobes,
  output logic              chainTcN
);
  // Low only when every stage is at all ones (OR of active-low flags)
  assign chainTcN      = |stageTcN;
  assign strobes.load  = ~loadN | (divMode & ~chainTcN);
  assign strobes.lsbEn = ~cntEnN;
endmodule

// File: rtl/wcc_datapath.sv
`timescale 1ns/1ps
module wcc_datapath
  import wcc_pkg::*;
#(
  parameter int STAGES = 2,
  parameter int SW     = 8
) (
  input  logic                 clk,
  input  logic                 arst,
  input  wccStrobes_t          strobes,
  input  logic [STAGES*SW-1:0] presetVal,
  output logic [STAGES*SW-1:0] countVal,
  output logic [STAGES-1:0]    stageTcN
);
  localparam int W = STAGES * SW;

  logic [STAGES-1:0] stageEnN;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_lsb
      assign stageEnN[k] = ~strobes.lsbEn;
    end else begin : g_upper
      // Enabled only when all lower stages sit at terminal count
      assign stageEnN[k] = |stageTcN[k-1:0];
    end

    wcc_stage #(.SW(SW)) u_stage (
      .clk         (clk),
      .arst        (arst),
      .load        (strobes.load),
      .enN         (stageEnN[k]),
      .presetSlice (presetVal[k*SW +: SW]),
      .q           (countVal[k*SW +: SW]),
      .tcN         (stageTcN[k])
    );
  end

  // R2
  load_chk: assert property (@(posedge clk) disable iff (arst)
    strobes.load |=> countVal == $past(presetVal));

  // R4
  lsb_hold_chk: assert property (@(posedge clk) disable iff (arst)
    (!strobes.load && !strobes.lsbEn) |=> $stable(countVal[SW-1:0]));

  logic unusedW;
  assign unusedW = (W == 0);
endmodule

// File: rtl/wide_count_chain.sv
`timescale 1ns/1ps
module wide_count_chain
  import wcc_pkg::*;
#(
  parameter int STAGES  = 2,
  parameter int STAGE_W = 8
) (
  input  logic                      clk,
  input  logic                      arst,
  input  logic                      cntEnN,
  input  logic                      loadN,
  input  logic                      divMode,
  input  logic [STAGES*STAGE_W-1:0] presetVal,
  output logic [STAGES*STAGE_W-1:0] countVal,
  output logic                      termN
);
  localparam int W = STAGES * STAGE_W;
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  wccStrobes_t       strobes;
  logic [STAGES-1:0] stageTcN;

  wcc_ctrl #(.STAGES(STAGES)) u_ctrl (
    .cntEnN   (cntEnN),
    .loadN    (loadN),
    .divMode  (divMode),
    .stageTcN (stageTcN),
    .strobes  (strobes),
    .chainTcN (termN)
  );

  wcc_datapath #(.STAGES(STAGES), .SW(STAGE_W)) u_dp (
    .clk       (clk),
    .arst      (arst),
    .strobes   (strobes),
    .presetVal (presetVal),
    .countVal  (countVal),
    .stageTcN  (stageTcN)
  );

  // R6
  term_match_chk: assert property (@(posedge clk) disable iff (arst)
    (termN == 1'b0) == (countVal == ALL_ONES));

  // R3
  count_inc_chk: assert property (@(posedge clk) disable iff (arst)
    (loadN && !cntEnN && !(divMode && countVal == ALL_ONES))
      |=> countVal == $past(countVal) + 1'b1);

  // R7
  div_reload_chk: assert property (@(posedge clk) disable iff (arst)
    (divMode && loadN && countVal == ALL_ONES) |=> countVal == $past(presetVal));

  // R9
  no_reload_chk: assert property (@(posedge clk) disable iff (arst)
    (!divMode && loadN && !cntEnN && countVal == ALL_ONES) |=> countVal == '0);
endmodule

// File: tb/wide_count_chain_tb.sv
`timescale 1ns/1ps
module wide_count_chain_tb;
  localparam int S  = 2;
  localparam int SW = 8;
  localparam int W  = S * SW;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic arst = 1'b1;
  logic cntEnN = 1'b1;
  logic loadN = 1'b1;
  logic divMode = 1'b0;
  logic [W-1:0] presetVal = '0;
  logic [W-1:0] countVal;
  logic termN;

  int tests = 0;
  int fails = 0;
  logic [W-1:0] refCnt = '0;
  logic [31:0] lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  wide_count_chain #(.STAGES(S), .STAGE_W(SW)) u_dut (
    .clk(clk), .arst(arst), .cntEnN(cntEnN), .loadN(loadN),
    .divMode(divMode), .presetVal(presetVal), .countVal(countVal), .termN(termN)
  );

  function automatic logic [W-1:0] nextRef(input logic [W-1:0] cur, input logic ceN,
                                           input logic ldN, input logic dm,
                                           input logic [W-1:0] pre);
    logic [W-1:0] r;
    if (!ldN) return pre;
    if (dm && cur == ONES) return pre;
    r = cur;
    for (int k = 0; k < S; k++) begin
      logic en;
      logic [W-1:0] lowMask;
      if (k == 0) en = !ceN;
      else begin
        lowMask = (W'(1) << (k * SW)) - 1'b1;
        en = ((cur & lowMask) == lowMask);
      end
      if (en) r[k*SW +: SW] = cur[k*SW +: SW] + 1'b1;
    end
    return r;
  endfunction

  task automatic checkEq(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // One edge; reference advanced with the inputs seen at that edge
  task automatic step(input string tag);
    logic [W-1:0] nxt;
    nxt = nextRef(refCnt, cntEnN, loadN, divMode, presetVal);
    @(posedge clk); #1;
    refCnt = nxt;
    checkEq(tag, countVal, refCnt);
    checkEq({tag, " R6 termN"}, W'(termN), W'(refCnt != ONES));
  endtask

  task automatic loadWord(input logic [W-1:0] v, input logic ceN);
    presetVal = v; loadN = 1'b0; cntEnN = ceN;
    step("R2 load");
    loadN = 1'b1;
  endtask

  task automatic measure(input logic [W-1:0] p);
    int n;
    divMode = 1'b1;
    loadWord(ONES, 1'b0);
    presetVal = p;
    checkEq("R6 term at ones", W'(termN), W'(0));
    n = 0;
    do begin
      step("R8 div count");
      n++;
      if (n == 1 && p != ONES) checkEq("R8 pulse width", W'(termN), W'(1));
    end while (termN !== 1'b0 && n < 70000);
    checkEq("R8 period", W'(n), W'((1 << W) - int'(p)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkEq("R1 reset count", countVal, '0);
    checkEq("R1 reset term", W'(termN), W'(1));
    arst = 1'b0;

    // R2 load with enable off and on
    loadWord(16'h3C5A, 1'b1);
    loadWord(16'hA5C3, 1'b0);

    // R5 carry across the stage boundary
    loadWord(16'h00FE, 1'b0);
    step("R5 to 00FF"); step("R5 to 0100");
    checkEq("R5 carry", countVal, 16'h0100);

    // R9 wrap without reload
    divMode = 1'b0;
    loadWord(16'hFFFE, 1'b0);
    step("R9 ones"); step("R9 wrap");
    checkEq("R9 wrap zero", countVal, '0);

    // R4 lsb held, upper stage still advances
    loadWord(16'h05FF, 1'b1);
    step("R4 upper adv"); checkEq("R4 upper 06FF", countVal, 16'h06FF);
    step("R4 upper adv"); checkEq("R4 upper 07FF", countVal, 16'h07FF);
    loadWord(16'h0512, 1'b1);
    step("R4 hold"); checkEq("R4 hold 0512", countVal, 16'h0512);

    // R7 divider reload with enable off
    divMode = 1'b1;
    loadWord(ONES, 1'b1);
    presetVal = 16'h1234;
    step("R7 reload"); checkEq("R7 reload value", countVal, 16'h1234);

    // R3 sweep: many presets, pseudo-random enable, both modes
    for (int t = 0; t < 60; t++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      divMode = lcg[3];
      loadWord(divMode ? (lcg[31:16] | 16'hFFE0) : lcg[31:16], lcg[5]);
      for (int c = 0; c < 48; c++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        cntEnN = (lcg[30:28] == 3'd0);
        step("R3 sweep");
      end
    end

    // R1 asynchronous reset between edges
    cntEnN = 1'b0;
    #1 arst = 1'b1;
    #1;
    checkEq("R1 async count", countVal, '0);
    checkEq("R1 async term", W'(termN), W'(1));
    @(posedge clk); #1;
    arst = 1'b0; refCnt = '0;

    // R8 divider periods
    cntEnN = 1'b0;
    measure(16'hFFFE);
    measure(16'hFF00);
    measure(16'h8F00 | 16'h7000);
    measure(16'h0000);

    summary();
  end
endmodule